// File: doc/BRIEF.md
# Retention-Aware Row Refresh Scheduler

This block sits in a memory controller and decides which rows receive a refresh in each base period. Most rows keep their data far longer than the worst-case guarantee, so refreshing every row at the fastest rate wastes energy and bank time. Before the sweep starts, software records the weak rows in two small Bloom filters, one for each retention bin. A row in the first bin is refreshed every base period. A row in the second bin is refreshed every second period. Every other row is refreshed once every four periods.

A row pointer walks the whole address space once per base period. A two-bit epoch counter counts the periods. For each row, the block looks the row up in both filters, works out its class, and offers a refresh request only when that class is due in the current epoch. Requests leave on a valid/ready pair that carries the row address and the class. A request that is not accepted holds the sweep in place, so no due row is lost. A divider sets how many clock cycles each row slot takes, which lets a simulation compress the real period. A false positive in a filter can only make a row refresh more often than it needs to.

Top module: `retention_refresh_sched`

## Requirements
- R1: After reset both filters are empty, `req_valid` is 0, and the sweep starts at row 0 in epoch 0.
- R2: A cycle with `cfg_ins` high and `cfg_clr` low sets two bits in the filter that `cfg_bin` selects. Bit 0 of `cfg_bin` picks filter 0 (fast bin) when 0 and filter 1 when 1. The bit indices are h0 = F(row) and h1 = F(rotl5(row)) XOR 0x2B5. F XOR-folds the 12-bit row: address bit j goes into index bit (j mod 10). rotl5 is a left rotate by 5 over 12 bits.
- R3: A row is a member of a filter when the bits at both its h0 and h1 indices are set. A row that matches only because other inserted rows set those bits is treated as a member.
- R4: `req_class` is 0 when the row is a member of filter 0. It is 1 when the row is a member of filter 1 only. It is 2 when the row is a member of neither filter.
- R5: Class 0 rows are due in every epoch, class 1 rows when bit 0 of the epoch is 0, and class 2 rows only in epoch 0. The epoch increments modulo 4 each time the pointer steps from the last row to row 0.
- R6: Requests come out in ascending row order within an epoch. Every due row is requested exactly once per epoch, and no row that is not due is requested.
- R7: While `req_valid` is 1 and `req_ready` is 0, `req_valid`, `req_row` and `req_class` hold their values and the sweep does not advance.
- R8: With `req_ready` held at 1 and every row due, accepted requests are spaced exactly `step_div`+1 cycles apart.
- R9: A cycle with `cfg_clr` high clears every bit of the filter that `cfg_bin` selects. This wins over a simultaneous `cfg_ins`.
- R10: While `run` is 0, no new request is raised and the pointer holds. A request that is already pending can still be accepted. Raising `run` again resumes the sweep at the held row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Enables the refresh sweep |
| step_div | input | 8 | Row slot length minus one, in cycles |
| cfg_ins | input | 1 | Insert `cfg_row` into the selected filter |
| cfg_clr | input | 1 | Clear the selected filter |
| cfg_bin | input | 1 | Filter select: 0 fast bin, 1 medium bin |
| cfg_row | input | 12 | Row address to insert |
| req_ready | input | 1 | Consumer accepts the request |
| req_valid | output | 1 | A refresh request is offered |
| req_row | output | 12 | Row address to refresh |
| req_class | output | 2 | Retention class of the requested row |

## Verification
The hardest situations to reach are a slow-bin or default row being skipped or duplicated at an epoch boundary while the consumer stalls, and a row that is a member only through a filter false positive. The stimulus fills both filters with a few hundred overlapping rows, so that collisions occur by themselves. It then runs more than four full sweeps while `req_ready` follows a periodic pattern with one long low window. A bit-accurate filter model checks every accepted request against the next due row that the model predicts.

// File: rtl/rr_pkg.sv
package rr_pkg;
  typedef enum logic [1:0] {
    CLS_FAST = 2'd0,
    CLS_MED  = 2'd1,
    CLS_SLOW = 2'd2
  } rr_class_e;

  localparam int unsigned NUM_BINS = 2;
  localparam int unsigned EPOCH_W  = 2;
endpackage

// File: rtl/rr_bloom.sv
module rr_bloom #(
  parameter int unsigned ROW_W = 12,
  parameter int unsigned IDX_W = 10,
  parameter int unsigned ROT   = 5,
  parameter int unsigned SALT  = 693
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins,
  input  logic             clr,
  input  logic [ROW_W-1:0] ins_row,
  input  logic [ROW_W-1:0] look_row,
  output logic             hit
);
  localparam int unsigned NBITS = 1 << IDX_W;
  localparam logic [IDX_W-1:0] SALT_V = IDX_W'(SALT);

  function automatic logic [IDX_W-1:0] fold(input logic [ROW_W-1:0] v);
    logic [IDX_W-1:0] f;
    f = '0;
    for (int j = 0; j < ROW_W; j++) f[j % IDX_W] = f[j % IDX_W] ^ v[j];
    return f;
  endfunction

  function automatic logic [ROW_W-1:0] rotl(input logic [ROW_W-1:0] v);
    return (v << ROT) | (v >> (ROW_W - ROT));
  endfunction

  logic [NBITS-1:0] bits_q, bits_d;
  logic [IDX_W-1:0] ins_h0, ins_h1, look_h0, look_h1;
  logic             upd;

  assign ins_h0  = fold(ins_row);
  assign ins_h1  = fold(rotl(ins_row)) ^ SALT_V;
  assign look_h0 = fold(look_row);
  assign look_h1 = fold(rotl(look_row)) ^ SALT_V;
  assign upd     = ins | clr;

  always_comb begin
    bits_d = bits_q;
    if (clr) begin
      bits_d = '0;
    end else if (ins) begin
      bits_d[ins_h0] = 1'b1;
      bits_d[ins_h1] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   bits_q <= '0;
    else if (upd) bits_q <= bits_d;
  end

  assign hit = bits_q[look_h0] & bits_q[look_h1];

  a_r9_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (bits_q == '0));
  a_r2_insert_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (ins && !clr) |=> (bits_q[$past(ins_h0)] && bits_q[$past(ins_h1)]));
endmodule

// File: rtl/rr_tick.sv
module rr_tick #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] limit,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             wrap;

  assign wrap = (cnt_q >= limit);
  assign tick = en & wrap;

  always_comb begin
    cnt_d = wrap ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt_q <= '0;
    else if (en) cnt_q <= cnt_d;
  end

  a_r10_hold_count: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(cnt_q));
endmodule

// File: rtl/retention_refresh_sched.sv
module retention_refresh_sched
  import rr_pkg::*;
#(
  parameter int unsigned ROW_W = 12,
  parameter int unsigned IDX_W = 10,
  parameter int unsigned ROT   = 5,
  parameter int unsigned SALT  = 693,
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] step_div,
  input  logic             cfg_ins,
  input  logic             cfg_clr,
  input  logic             cfg_bin,
  input  logic [ROW_W-1:0] cfg_row,
  input  logic             req_ready,
  output logic             req_valid,
  output logic [ROW_W-1:0] req_row,
  output logic [1:0]       req_class
);
  localparam logic [ROW_W-1:0] ROW_LAST = {ROW_W{1'b1}};

  logic [ROW_W-1:0]   row_q, row_d;
  logic [EPOCH_W-1:0] ep_q, ep_d;
  logic               vld_q, vld_d;
  logic [ROW_W-1:0]   rrow_q, rrow_d;
  rr_class_e          rcls_q, rcls_d;
  logic [NUM_BINS-1:0] hit;
  logic               stall, tick, due;
  rr_class_e          cls;

  for (genvar b = 0; b < NUM_BINS; b++) begin : g_bin
    rr_bloom #(.ROW_W(ROW_W), .IDX_W(IDX_W), .ROT(ROT), .SALT(SALT)) bloom_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .ins      (cfg_ins && (cfg_bin == 1'(b))),
      .clr      (cfg_clr && (cfg_bin == 1'(b))),
      .ins_row  (cfg_row),
      .look_row (row_q),
      .hit      (hit[b])
    );
  end

  assign stall = vld_q & ~req_ready;

  rr_tick #(.DIV_W(DIV_W)) tick_i (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (run & ~stall),
    .limit (step_div),
    .tick  (tick)
  );

  always_comb begin
    if (hit[0])      cls = CLS_FAST;
    else if (hit[1]) cls = CLS_MED;
    else             cls = CLS_SLOW;
    unique case (cls)
      CLS_FAST: due = 1'b1;
      CLS_MED:  due = ~ep_q[0];
      default:  due = (ep_q == '0);
    endcase
  end

  always_comb begin
    row_d  = row_q;
    ep_d   = ep_q;
    vld_d  = stall;
    rrow_d = rrow_q;
    rcls_d = rcls_q;
    if (tick) begin
      vld_d = due;
      if (due) begin
        rrow_d = row_q;
        rcls_d = cls;
      end
      row_d = row_q + 1'b1;
      if (row_q == ROW_LAST) ep_d = ep_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q  <= '0;
      ep_q   <= '0;
      vld_q  <= 1'b0;
      rrow_q <= '0;
      rcls_q <= CLS_FAST;
    end else begin
      vld_q <= vld_d;
      if (tick) begin
        row_q  <= row_d;
        ep_q   <= ep_d;
        rrow_q <= rrow_d;
        rcls_q <= rcls_d;
      end
    end
  end

  assign req_valid = vld_q;
  assign req_row   = rrow_q;
  assign req_class = rcls_q;

  a_r7_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_row) && $stable(req_class)));
  a_r7_freeze_sweep: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> $stable(row_q));
  a_r10_idle_no_new: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !req_valid) |=> !req_valid);
  a_r5_epoch_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (ep_q != $past(ep_q)) |-> (row_q == '0));
  a_r4_class_legal: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_class != 2'd3));
  a_r5_slow_epoch0: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_class == 2'd2)) |-> ((ep_q == '0) || (req_row == ROW_LAST)));
endmodule

// File: tb/retention_refresh_sched_tb_top.sv
module retention_refresh_sched_tb_top;
  localparam int NROWS = 4096;
  localparam int NIDX  = 1024;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        run;
  logic [7:0]  step_div;
  logic        cfg_ins, cfg_clr, cfg_bin;
  logic [11:0] cfg_row;
  logic        req_ready;
  logic        req_valid;
  logic [11:0] req_row;
  logic [1:0]  req_class;

  always #10 clk = ~clk;

  retention_refresh_sched dut_i (
    .clk(clk), .rst_n(rst_n), .run(run), .step_div(step_div),
    .cfg_ins(cfg_ins), .cfg_clr(cfg_clr), .cfg_bin(cfg_bin), .cfg_row(cfg_row),
    .req_ready(req_ready), .req_valid(req_valid), .req_row(req_row), .req_class(req_class)
  );

  int checks = 0;
  int errors = 0;
  bit mbf [2][NIDX];
  int m_row, m_ep;
  int cyc = 0;
  int ready_mode = 0;
  bit prev_stall;
  int prev_row, prev_cls;
  bit idle_expect = 0;
  bit spacing_on = 0;
  int spacing_cnt = 0;
  int last_hs = -1;
  int hs_cls [3];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int fold(input int v);
    int f = 0;
    for (int j = 0; j < 12; j++) if ((v >> j) & 1) f = f ^ (1 << (j % 10));
    return f;
  endfunction

  function automatic int h0(input int r);
    return fold(r);
  endfunction

  function automatic int h1(input int r);
    int rr = ((r << 5) | (r >> 7)) & 12'hFFF;
    return fold(rr) ^ 10'h2B5;
  endfunction

  function automatic int cls_of(input int r);
    if (mbf[0][h0(r)] && mbf[0][h1(r)]) return 0;
    if (mbf[1][h0(r)] && mbf[1][h1(r)]) return 1;
    return 2;
  endfunction

  function automatic bit is_due(input int c, input int ep);
    return (c == 0) || (c == 1 && (ep % 2) == 0) || (c == 2 && ep == 0);
  endfunction

  task automatic m_adv();
    m_row++;
    if (m_row == NROWS) begin
      m_row = 0;
      m_ep = (m_ep + 1) % 4;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; run = 1'b0; cfg_ins = 0; cfg_clr = 0; cfg_bin = 0; cfg_row = '0;
    req_ready = 1'b1; step_div = '0;
    for (int b = 0; b < 2; b++) for (int i = 0; i < NIDX; i++) mbf[b][i] = 0;
    m_row = 0; m_ep = 0; prev_stall = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic ins(input int bin, input int row);
    @(negedge clk);
    cfg_ins = 1; cfg_bin = bin[0]; cfg_row = row[11:0];
    @(negedge clk);
    cfg_ins = 0;
    mbf[bin][h0(row)] = 1;
    mbf[bin][h1(row)] = 1;
  endtask

  task automatic clr(input int bin, input bit with_ins, input int row);
    @(negedge clk);
    cfg_clr = 1; cfg_ins = with_ins; cfg_bin = bin[0]; cfg_row = row[11:0];
    @(negedge clk);
    cfg_clr = 0; cfg_ins = 0;
    for (int i = 0; i < NIDX; i++) mbf[bin][i] = 0;
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cyc++;
      if (ready_mode == 0) req_ready = 1'b1;
      else req_ready = !((cyc % 5) == 2 || (cyc % 5) == 3 || (cyc % 4000 >= 1000 && cyc % 4000 < 1025));
      if (prev_stall)
        chk(req_valid && req_row == prev_row[11:0] && req_class == prev_cls[1:0],
            "R7 hold during stall", int'(req_row), prev_row);
      if (idle_expect) chk(!req_valid, "R10 no request while halted", int'(req_valid), 0);
      prev_stall = req_valid && !req_ready;
      prev_row = req_row;
      prev_cls = req_class;
      if (req_valid && req_ready) begin
        while (!is_due(cls_of(m_row), m_ep)) m_adv();
        chk(int'(req_row) == m_row, "R6 R2 R3 next due row", int'(req_row), m_row);
        chk(int'(req_class) == cls_of(m_row), "R4 R5 class", int'(req_class), cls_of(m_row));
        hs_cls[req_class]++;
        m_adv();
        if (spacing_on && spacing_cnt < 12) begin
          if (last_hs >= 0)
            chk(cyc - last_hs == int'(step_div) + 1, "R8 slot spacing", cyc - last_hs, int'(step_div) + 1);
          spacing_cnt++;
        end
        last_hs = cyc;
      end
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL R6 watchdog act=timeout exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < 3; c++) hs_cls[c] = 0;
    do_reset();
    // R1: idle after reset while not running
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!req_valid, "R1 no request after reset", int'(req_valid), 0);
    end

    // R8 / R1: no filters, all rows due in epoch 0, starting at row 0
    step_div = 8'd3;
    run = 1'b1;
    spacing_on = 1;
    cycles(60);
    spacing_on = 0;
    chk(hs_cls[2] > 0, "R1 default rows served from row 0", hs_cls[2], 1);
    // R10: halt the sweep
    run = 1'b0;
    idle_expect = 1;
    cycles(30);
    idle_expect = 0;
    run = 1'b1;
    cycles(200);

    // R2 R3 R4 R5 R6 R7: populated filters, stalling consumer, several sweeps
    do_reset();
    for (int k = 0; k < 150; k++) ins(0, (k * 37 + 5) % NROWS);
    for (int k = 0; k < 150; k++) ins(1, (k * 53 + 11) % NROWS);
    for (int k = 0; k < 20; k++) ins(1, (k * 37 + 5) % NROWS);
    for (int c = 0; c < 3; c++) hs_cls[c] = 0;
    step_div = 8'd0;
    ready_mode = 1;
    run = 1'b1;
    cycles(42000);
    chk(hs_cls[0] > 0, "R4 fast class seen", hs_cls[0], 1);
    chk(hs_cls[1] > 0, "R4 medium class seen", hs_cls[1], 1);
    chk(m_ep != 0 || m_row > 0, "R5 epochs advanced", m_ep, 1);

    // R9: clear of a filter, and clear winning over insert
    do_reset();
    for (int k = 0; k < 40; k++) ins(0, k * 97 % NROWS);
    for (int k = 0; k < 40; k++) ins(1, (k * 61 + 3) % NROWS);
    clr(0, 1'b0, 0);
    clr(1, 1'b1, 123);
    for (int k = 0; k < 10; k++) ins(1, k * 7 + 1);
    for (int c = 0; c < 3; c++) hs_cls[c] = 0;
    ready_mode = 0;
    run = 1'b1;
    cycles(17000);
    chk(hs_cls[0] == 0, "R9 cleared fast filter has no members", hs_cls[0], 0);
    chk(hs_cls[1] > 0, "R9 reinserted medium rows served", hs_cls[1], 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule